// File: doc/BRIEF.md
# NAPOT Physical Memory Protection Checker

This block guards physical memory with a small bank of protection entries. Each entry holds a one-byte configuration (read, write and execute permissions, an address-match mode and a lock flag) and a word-granular address register. For every access the block is given a physical address, an access class and a flag saying whether the requester runs in machine mode. In the same cycle it answers whether the access faults and, when it does, which kind of access fault it is.

The only region shape supported is the naturally aligned power-of-two region. Its size is encoded by the run of ones at the bottom of the address register. The lowest-numbered entry whose region contains the address decides the outcome. Machine mode is trusted unless the deciding entry is locked. A lock freezes the entry until reset.

The configuration and address registers are written through simple one-cycle write strobes. A write becomes visible from the next clock edge. The access check is purely combinational on the stored state and the access inputs.

Top module: `pmp_guard`

## Requirements
- R1: When an entry decides an access and its permissions apply, a fetch needs the X bit (cfg bit 2), a load needs R (bit 0), and a store or atomic needs W (bit 1). A missing permission raises `fault`.
- R2: `acc_kind` is encoded 00 fetch, 01 load or load-reserved, 10 store or store-conditional, 11 atomic. When `fault` is 1, `fault_cause` is 00 for fetch, 01 for load and 10 for both store and atomic. When `fault` is 0, `fault_cause` is 00.
- R3: An entry in match mode 11 (cfg bits 4:3) whose address register ends in k ones above a zero covers the 2^(k+3)-byte region aligned to its size. The region's word address is the register with its low k+1 bits cleared, and the register holds physical address bits 33:2.
- R4: An address register of all ones matches no access, even in match mode 11.
- R5: Configuration writes are legalised. When R is written as 0, W is stored as 0. A match mode other than 11 is stored as 00 (off). Bits 6:5 are stored as 0.
- R6: When several entries contain the address, the lowest-numbered one alone decides.
- R7: When no entry matches, a machine-mode access is allowed and any other access faults.
- R8: When the deciding entry is unlocked (cfg bit 7 clear), a machine-mode access is allowed whatever its permissions. When it is locked, its permissions also bind machine mode.
- R9: While an entry is locked, writes to its configuration and to its address register are ignored until reset.
- R10: A write changes the decision from the cycle after its strobe. An access in the same cycle as a write is judged on the old contents.
- R11: After reset every entry is off and unlocked, with its address register at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_idx | input | 2 | Entry selected for configuration write |
| cfg_wr_data | input | 8 | Configuration byte to write |
| addr_wr_en | input | 1 | Address register write strobe |
| addr_wr_idx | input | 2 | Entry selected for address write |
| addr_wr_data | input | 32 | Address register value (physical bits 33:2) |
| acc_addr | input | 34 | Physical byte address of the access |
| acc_kind | input | 2 | Access class |
| acc_mach | input | 1 | Access made in machine mode |
| fault | output | 1 | Access fault |
| fault_cause | output | 2 | Fault kind: fetch, load or store |

## Verification
An entry can be rewritten, or locked, in the same cycle as an access that it decides. The old contents must then judge that access, and the new contents only the next one. The bench provokes this directly: it downgrades an entry's permissions while issuing a store to that entry. It also draws random write strobes and accesses in the same cycles throughout a long random run. A reference model in the bench updates its copy of the entries only after the clock edge and predicts every decision from that copy.

// File: rtl/pmp_guard_pkg.sv
package pmp_guard_pkg;

    // access classes as seen on acc_kind
    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_LOAD  = 2'b01,
        KIND_STORE = 2'b10,
        KIND_AMO   = 2'b11
    } acc_kind_e;

    localparam logic [1:0] MODE_OFF   = 2'b00;
    localparam logic [1:0] MODE_NAPOT = 2'b11;

    localparam logic [1:0] CAUSE_FETCH = 2'b00;
    localparam logic [1:0] CAUSE_LOAD  = 2'b01;
    localparam logic [1:0] CAUSE_STORE = 2'b10;

    // one configuration byte, MSB first
    typedef struct packed {
        logic       lock;
        logic [1:0] rsvd;
        logic [1:0] mode;
        logic       x;
        logic       w;
        logic       r;
    } pmp_cfg_t;

    // turn a raw written byte into a storable configuration
    function automatic pmp_cfg_t cfg_legalise(input logic [7:0] raw);
        pmp_cfg_t c;
        c      = pmp_cfg_t'(raw);
        c.rsvd = 2'b00;
        c.w    = raw[1] & raw[0];
        c.mode = (raw[4:3] == MODE_NAPOT) ? MODE_NAPOT : MODE_OFF;
        return c;
    endfunction

endpackage

// File: rtl/pmp_entry_bank.sv
module pmp_entry_bank
    import pmp_guard_pkg::*;
#(
    parameter int N     = 4,
    parameter int AW    = 32,
    parameter int IDX_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr_en,
    input  logic [IDX_W-1:0]         cfg_wr_idx,
    input  logic [7:0]               cfg_wr_data,
    input  logic                     addr_wr_en,
    input  logic [IDX_W-1:0]         addr_wr_idx,
    input  logic [AW-1:0]            addr_wr_data,
    output pmp_cfg_t [N-1:0]         cfg_o,
    output logic [N-1:0][AW-1:0]     addr_o
);

    typedef struct packed {
        pmp_cfg_t [N-1:0]     cfg;
        logic [N-1:0][AW-1:0] addr;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            // a lock seen in the current state blocks both writes
            if (cfg_wr_en && (cfg_wr_idx == IDX_W'(i)) && !st_q.cfg[i].lock)
                st_d.cfg[i] = cfg_legalise(cfg_wr_data);
            if (addr_wr_en && (addr_wr_idx == IDX_W'(i)) && !st_q.cfg[i].lock)
                st_d.addr[i] = addr_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o  = st_q.cfg;
    assign addr_o = st_q.addr;

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_NO_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            !(st_q.cfg[g].w && !st_q.cfg[g].r)); // R5
        AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.cfg[g].mode == MODE_OFF) || (st_q.cfg[g].mode == MODE_NAPOT)); // R5
        AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.cfg[g].lock |=> ($stable(st_q.cfg[g]) && $stable(st_q.addr[g]))); // R9
    end

endmodule

// File: rtl/pmp_napot_match.sv
module pmp_napot_match
    import pmp_guard_pkg::*;
#(
    parameter int AW = 32
) (
    input  pmp_cfg_t      cfg_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] word_i,
    output logic          hit_o
);

    logic [AW-1:0] low_run;
    logic [AW-1:0] care;
    logic          reserved;

    always_comb begin
        // k trailing ones plus the zero above them mark the ignored bits
        low_run  = addr_i ^ (addr_i + AW'(1));
        care     = ~low_run;
        reserved = &addr_i;
        hit_o    = (cfg_i.mode == MODE_NAPOT) && !reserved
                   && (((word_i ^ addr_i) & care) == '0);
    end

endmodule

// File: rtl/pmp_prio_resolve.sv
module pmp_prio_resolve
    import pmp_guard_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0]     hit_i,
    input  pmp_cfg_t [N-1:0] cfg_i,
    input  acc_kind_e        kind_i,
    input  logic             mach_i,
    output logic             fault_o,
    output logic [1:0]       cause_o
);

    logic found;
    logic allow;

    always_comb begin
        found = 1'b0;
        allow = mach_i;
        for (int i = 0; i < N; i++) begin
            if (!found && hit_i[i]) begin
                found = 1'b1;
                if (mach_i && !cfg_i[i].lock) begin
                    allow = 1'b1;
                end else begin
                    case (kind_i)
                        KIND_FETCH: allow = cfg_i[i].x;
                        KIND_LOAD:  allow = cfg_i[i].r;
                        default:    allow = cfg_i[i].w;
                    endcase
                end
            end
        end
        fault_o = !allow;
        if (!allow) begin
            case (kind_i)
                KIND_FETCH: cause_o = CAUSE_FETCH;
                KIND_LOAD:  cause_o = CAUSE_LOAD;
                default:    cause_o = CAUSE_STORE;
            endcase
        end else begin
            cause_o = CAUSE_FETCH;
        end
    end

endmodule

// File: rtl/pmp_guard.sv
module pmp_guard
    import pmp_guard_pkg::*;
#(
    parameter int  N       = 4,
    parameter int  PADDR_W = 34,
    localparam int IDX_W   = (N > 1) ? $clog2(N) : 1,
    localparam int AW      = PADDR_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [IDX_W-1:0]   cfg_wr_idx,
    input  logic [7:0]         cfg_wr_data,
    input  logic               addr_wr_en,
    input  logic [IDX_W-1:0]   addr_wr_idx,
    input  logic [AW-1:0]      addr_wr_data,
    input  logic [PADDR_W-1:0] acc_addr,
    input  logic [1:0]         acc_kind,
    input  logic               acc_mach,
    output logic               fault,
    output logic [1:0]         fault_cause
);

    pmp_cfg_t [N-1:0]     bank_cfg;
    logic [N-1:0][AW-1:0] bank_addr;
    logic [N-1:0]         hit;
    logic [AW-1:0]        acc_word;
    acc_kind_e            kind;

    assign acc_word = acc_addr[PADDR_W-1:2];
    assign kind     = acc_kind_e'(acc_kind);

    pmp_entry_bank #(.N(N), .AW(AW), .IDX_W(IDX_W)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_idx   (cfg_wr_idx),
        .cfg_wr_data  (cfg_wr_data),
        .addr_wr_en   (addr_wr_en),
        .addr_wr_idx  (addr_wr_idx),
        .addr_wr_data (addr_wr_data),
        .cfg_o        (bank_cfg),
        .addr_o       (bank_addr)
    );

    for (genvar g = 0; g < N; g++) begin : g_match
        pmp_napot_match #(.AW(AW)) u_match (
            .cfg_i  (bank_cfg[g]),
            .addr_i (bank_addr[g]),
            .word_i (acc_word),
            .hit_o  (hit[g])
        );

        AST_RESERVED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            (&bank_addr[g]) |-> !hit[g]); // R4
    end

    pmp_prio_resolve #(.N(N)) u_resolve (
        .hit_i   (hit),
        .cfg_i   (bank_cfg),
        .kind_i  (kind),
        .mach_i  (acc_mach),
        .fault_o (fault),
        .cause_o (fault_cause)
    );

    AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> (fault_cause == CAUSE_FETCH)); // R2
    AST_CAUSE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_cause == (acc_kind[1] ? CAUSE_STORE : acc_kind))); // R2
    AST_NO_MATCH_MACH: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit == '0) && acc_mach) |-> !fault); // R7
    AST_NO_MATCH_USER: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit == '0) && !acc_mach) |-> fault); // R7

endmodule

// File: tb/tb_pmp_guard.sv
`timescale 1ns/1ps
module tb_pmp_guard;

    localparam int N  = 4;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [1:0]  cfg_wr_idx;
    logic [7:0]  cfg_wr_data;
    logic        addr_wr_en;
    logic [1:0]  addr_wr_idx;
    logic [31:0] addr_wr_data;
    logic [33:0] acc_addr;
    logic [1:0]  acc_kind;
    logic        acc_mach;
    logic        fault;
    logic [1:0]  fault_cause;

    always #2 clk = ~clk;

    pmp_guard dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
        .addr_wr_en(addr_wr_en), .addr_wr_idx(addr_wr_idx), .addr_wr_data(addr_wr_data),
        .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_mach(acc_mach),
        .fault(fault), .fault_cause(fault_cause)
    );

    int errors = 0;
    int checks = 0;

    logic [7:0]    m_cfg  [N];
    logic [AW-1:0] m_addr [N];

    function automatic logic [7:0] legal(input logic [7:0] d);
        logic [7:0] o;
        o      = 8'h00;
        o[0]   = d[0];
        o[1]   = d[1] & d[0];
        o[2]   = d[2];
        o[4:3] = (d[4:3] == 2'b11) ? 2'b11 : 2'b00;
        o[7]   = d[7];
        return o;
    endfunction

    // returns {fault, cause}
    function automatic logic [2:0] predict(input logic [33:0] pa, input logic [1:0] k, input logic m);
        logic [AW-1:0] w;
        logic [AW-1:0] care;
        bit found;
        bit allow;
        bit hit;
        w     = pa[33:2];
        found = 0;
        allow = m;
        for (int i = 0; i < N; i++) begin
            care = ~(m_addr[i] ^ (m_addr[i] + 32'd1));
            hit  = (m_cfg[i][4:3] == 2'b11) && (m_addr[i] != '1)
                   && (((w ^ m_addr[i]) & care) == '0);
            if (!found && hit) begin
                found = 1;
                if (m && !m_cfg[i][7]) allow = 1;
                else begin
                    case (k)
                        2'd0:    allow = m_cfg[i][2];
                        2'd1:    allow = m_cfg[i][0];
                        default: allow = m_cfg[i][1];
                    endcase
                end
            end
        end
        if (allow) return 3'b000;
        return {1'b1, (k == 2'd3) ? 2'd2 : k};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_cfg[i]  = 8'h00;
            m_addr[i] = '0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n      = 1'b0;
        cfg_wr_en  = 1'b0;
        addr_wr_en = 1'b0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic ce, input int ci, input logic [7:0] cd,
                        input logic ae, input int ai, input logic [31:0] ad,
                        input logic [33:0] pa, input logic [1:0] k, input logic m,
                        input string tag);
        logic [2:0] exp;
        bit lk_c;
        bit lk_a;
        @(negedge clk);
        cfg_wr_en    = ce;
        cfg_wr_idx   = ci[1:0];
        cfg_wr_data  = cd;
        addr_wr_en   = ae;
        addr_wr_idx  = ai[1:0];
        addr_wr_data = ad;
        acc_addr     = pa;
        acc_kind     = k;
        acc_mach     = m;
        #1;
        exp = predict(pa, k, m);
        checks++;
        if ({fault, fault_cause} !== exp) begin
            errors++;
            $display("FAIL %s: addr=%h kind=%0d mach=%0b got fault=%0b cause=%0d expected fault=%0b cause=%0d",
                     tag, pa, k, m, fault, fault_cause, exp[2], exp[1:0]);
        end
        @(posedge clk);
        lk_c = m_cfg[ci[1:0]][7];
        lk_a = m_cfg[ai[1:0]][7];
        if (ce && !lk_c) m_cfg[ci[1:0]] = legal(cd);
        if (ae && !lk_a) m_addr[ai[1:0]] = ad;
    endtask

    task automatic acc(input logic [33:0] pa, input logic [1:0] k, input logic m, input string tag);
        step(1'b0, 0, 8'h00, 1'b0, 0, 32'h0, pa, k, m, tag);
    endtask

    task automatic wcfg(input int i, input logic [7:0] d);
        step(1'b1, i, d, 1'b0, 0, 32'h0, 34'h0, 2'd1, 1'b1, "R7");
    endtask

    task automatic waddr(input int i, input logic [31:0] d);
        step(1'b0, 0, 8'h00, 1'b1, i, d, 34'h0, 2'd1, 1'b1, "R7");
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        rst_n = 1'b0; cfg_wr_en = 0; cfg_wr_idx = 0; cfg_wr_data = 0;
        addr_wr_en = 0; addr_wr_idx = 0; addr_wr_data = 0;
        acc_addr = 0; acc_kind = 0; acc_mach = 0;
        model_reset();
        do_reset();

        // R11 reset state: all entries off
        acc(34'h0, 2'd1, 1'b0, "R11");
        acc(34'h1000, 2'd2, 1'b1, "R11");
        // R7 no match
        acc(34'h0, 2'd0, 1'b1, "R7");

        // entry 0: 4 KiB at 0x1000, R+X
        waddr(0, 32'h5FF);
        step(1'b1, 0, 8'h1D, 1'b0, 0, 32'h0, 34'h1000, 2'd1, 1'b0, "R10");
        acc(34'h1000, 2'd1, 1'b0, "R1");
        acc(34'h1FFC, 2'd2, 1'b0, "R1");
        acc(34'h1004, 2'd3, 1'b0, "R2");
        acc(34'h1FFC, 2'd0, 1'b0, "R1");
        acc(34'h2000, 2'd1, 1'b0, "R3");
        acc(34'h0FFC, 2'd1, 1'b0, "R3");
        acc(34'h1FFF, 2'd1, 1'b0, "R3");

        // entry 1: 8 bytes at 0x2000, write without read
        step(1'b1, 1, 8'h1A, 1'b1, 1, 32'h800, 34'h0, 2'd1, 1'b1, "R7");
        acc(34'h2000, 2'd2, 1'b0, "R5");
        wcfg(1, 8'h1B);
        acc(34'h2004, 2'd2, 1'b0, "R5");
        acc(34'h2008, 2'd1, 1'b0, "R3");

        // entry 2: whole space, all permissions
        waddr(2, 32'h7FFFFFFF);
        wcfg(2, 8'h1F);
        acc(34'h1000, 2'd2, 1'b0, "R6");
        acc(34'h3000, 2'd2, 1'b0, "R6");
        acc(34'h2004, 2'd3, 1'b0, "R6");

        // entry 3 with unsupported mode stored as off
        wcfg(2, 8'h00);
        waddr(3, 32'hC00);
        wcfg(3, 8'h0F);
        acc(34'h3000, 2'd1, 1'b0, "R5");

        // reserved all-ones address
        waddr(3, 32'hFFFFFFFF);
        wcfg(3, 8'h1F);
        acc(34'h3000, 2'd1, 1'b0, "R4");
        acc(34'h3FFFFFFFC, 2'd0, 1'b0, "R4");
        acc(34'h3000, 2'd1, 1'b1, "R4");

        // machine mode and lock
        acc(34'h1000, 2'd2, 1'b1, "R8");
        wcfg(0, 8'h9D);
        acc(34'h1000, 2'd2, 1'b1, "R8");
        acc(34'h1000, 2'd1, 1'b1, "R8");

        // locked entry ignores writes
        wcfg(0, 8'h1F);
        acc(34'h1000, 2'd2, 1'b0, "R9");
        waddr(0, 32'h0);
        acc(34'h1000, 2'd1, 1'b0, "R9");
        acc(34'h0, 2'd1, 1'b0, "R9");

        // same-cycle write and access
        step(1'b1, 1, 8'h19, 1'b0, 0, 32'h0, 34'h2000, 2'd2, 1'b0, "R10");
        acc(34'h2000, 2'd2, 1'b0, "R10");

        // reset clears the lock
        do_reset();
        acc(34'h1000, 2'd2, 1'b0, "R11");
        acc(34'h1000, 2'd2, 1'b1, "R11");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [7:0]  cd;
            logic [31:0] ad;
            logic [31:0] base;
            logic [33:0] pa;
            int kk;
            if (n % 1000 == 999) do_reset();
            cd = 8'($urandom);
            if ($urandom % 2 == 0) cd[4:3] = 2'b11;
            if ($urandom % 8 != 0) cd[7] = 1'b0;
            kk   = $urandom % 8;
            base = $urandom % 65536;
            ad   = (base & ~((32'd1 << (kk + 1)) - 32'd1)) | ((32'd1 << kk) - 32'd1);
            if ($urandom % 32 == 0) ad = '1;
            pa = {16'h0, 18'($urandom)};
            if ($urandom % 16 == 0) pa = {2'($urandom), 32'($urandom)};
            step(($urandom % 4) == 0, $urandom % 4, cd,
                 ($urandom % 3) == 0, $urandom % 4, ad,
                 pa, 2'($urandom), 1'($urandom), "R6");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule